// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers sixteen maskable interrupt sources, one non-maskable source and a software break request. It holds one pending flag per maskable source, together with a mask bit and a one-bit priority class. It presents the single winning request to the processor on a request/acknowledge handshake, together with the vector address that request jumps to. The default order of the sources breaks ties inside a priority class.

A small stack of in-service levels decides nesting. A handler running at low class can be pre-empted by a high-class request. A handler running at high class blocks every maskable request. The non-maskable handler blocks a second non-maskable entry. The processor returns from a handler with a one-cycle return pulse, which restores the level that was active before. Source 0 is the watchdog overflow, which can be steered to either the maskable or the non-maskable path. Sources 1 to 4 come from external pins with selectable edge sensitivity. Sources 5 to 15 are single-cycle pulses from on-chip peripherals. A wake output goes high while any unmasked request is pending.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset the pending flags (sel 0) read 0, the masks (sel 1) read 0xFFFF, the priority flags (sel 2) and the configuration (sel 3) read 0, the control register (sel 4, bit 0 = global enable, bits 2:1 = level) reads 0, and int_req is low.
- R2: Among unmasked pending sources of equal priority class, the lowest index wins. Its vector is 0x0004 + 2*index, so index 15 gives 0x0022.
- R3: A source whose priority flag is 1 (high class) beats any low-class source, whatever the indices. Inside the high class the lowest index wins.
- R4: A pending source whose mask bit is 1 is never presented on int_req, but its flag stays readable at sel 0.
- R5: With the global enable at 0, no maskable request is presented. The non-maskable source and the break are still presented.
- R6: Acknowledging a maskable request clears its flag and the global enable, and pushes the current level. The new level is 1 for a low-class source and 2 for a high-class source. A return pulse pops the previous level.
- R7: At level 1 only a high-class request is presented. At level 2 no maskable request is presented.
- R8: With configuration bit 8 set, a watchdog overflow becomes a non-maskable request with vector 0x0004 and level 3 on entry, and it is held off while the level is 3. With bit 8 clear, the overflow sets pending flag 0.
- R9: A break pulse gives vector 0x003E, regardless of the global enable, and ahead of any maskable request. Entering it leaves the level unchanged, and a return pops the level.
- R10: Pin k sets flag k+1 on a rising edge when configuration bit k is 1, and on a falling edge when configuration bit 4+k is 1. A pin with neither bit set causes no flag.
- R11: wake is high exactly while an unmasked pending flag or a waiting non-maskable request exists, independent of the global enable.
- R12: A hardware request in the same cycle as an acknowledge or a software write to the same flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 11 | One-cycle requests from sources 15..5 |
| ext_pin | input | 4 | External pins feeding sources 4..1 |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| brk_exec | input | 1 | Break instruction pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | 16 | Vector address of the presented request |
| int_ack | input | 1 | Processor accepts the presented request |
| reti | input | 1 | Return-from-handler pulse |
| wake | output | 1 | Standby release |

## Verification
Clearing a flag on acknowledge and setting that same flag from hardware can fall in the same cycle. So can a software write to the flag register and a peripheral pulse. The bench presents source 5, then drives int_ack together with a fresh pulse on source 5 at the same falling edge. After the next rising edge it reads back the flag register and the control register. It expects the flag to still be set, the level to be 1 and the enable to be cleared. It then repeats the test with a write of zero to the flags that coincides with a pulse on source 6, and expects only flag 6 to be set.

// File: rtl/vpic_ctrl.sv
module vpic_ctrl #(
  parameter int NSRC = 16,
  parameter int EXT = 4,
  parameter int STK = 4,
  parameter int VW = 16,
  parameter logic [15:0] VBASE = 16'h0004,
  parameter logic [15:0] VBRK = 16'h003E
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NSRC-1:EXT+1] src_pulse,
  input  logic [EXT-1:0] ext_pin,
  input  logic wdt_ovf,
  input  logic brk_exec,
  input  logic reg_we,
  input  logic [2:0] reg_sel,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic int_req,
  output logic [VW-1:0] int_vec,
  input  logic int_ack,
  input  logic reti,
  output logic wake
);
  localparam int IW = $clog2(NSRC);
  localparam logic [1:0] L_NONE = 2'd0, L_LOW = 2'd1, L_HIGH = 2'd2, L_NMI = 2'd3;

  logic [NSRC-1:0] rf_q, mk_q, pr_q, hw_set, elig, hi;
  logic [EXT-1:0] rise_q, fall_q, pin_q;
  logic route_nmi_q, ie_q, nmi_q, brk_q;
  logic [1:0] lvl_q, lvl_n, base_lvl;
  logic [1:0] stk_q [STK];
  logic [1:0] stk_n [STK];
  logic [IW-1:0] idx_hi, idx_any, win_idx;
  logic hit_hi, hit_any, mask_ok, take_nmi, take_brk, take_msk, acc;

  always_comb begin
    hw_set = '0;
    hw_set[0] = wdt_ovf & ~route_nmi_q;
    for (int k = 0; k < EXT; k++)
      hw_set[k+1] = (ext_pin[k] & ~pin_q[k] & rise_q[k]) | (~ext_pin[k] & pin_q[k] & fall_q[k]);
    for (int i = EXT + 1; i < NSRC; i++)
      hw_set[i] = src_pulse[i];
  end

  assign elig = rf_q & ~mk_q;
  assign hi = elig & pr_q;

  always_comb begin
    hit_hi = 1'b0; hit_any = 1'b0; idx_hi = '0; idx_any = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hi[i]) begin hit_hi = 1'b1; idx_hi = IW'(i); end
      if (elig[i]) begin hit_any = 1'b1; idx_any = IW'(i); end
    end
  end

  assign win_idx = hit_hi ? idx_hi : idx_any;
  assign mask_ok = ie_q && hit_any && (lvl_q == L_NONE || (lvl_q == L_LOW && hit_hi));
  assign take_nmi = nmi_q && (lvl_q != L_NMI);
  assign take_brk = !take_nmi && brk_q;
  assign take_msk = !take_nmi && !brk_q && mask_ok;
  assign int_req = take_nmi | take_brk | take_msk;
  assign int_vec = take_msk ? VW'(VBASE) + (VW'(win_idx) << 1) : (take_brk ? VW'(VBRK) : VW'(VBASE));
  assign acc = int_ack & int_req;
  assign wake = (|elig) | nmi_q;

  always_comb begin
    base_lvl = reti ? stk_q[0] : lvl_q;
    for (int s = 0; s < STK; s++)
      stk_n[s] = reti ? ((s == STK - 1) ? L_NONE : stk_q[s+1]) : stk_q[s];
    lvl_n = base_lvl;
    if (acc) begin
      for (int s = STK - 1; s > 0; s--) stk_n[s] = stk_n[s-1];
      stk_n[0] = base_lvl;
      if (take_nmi) lvl_n = L_NMI;
      else if (take_brk) lvl_n = base_lvl;
      else lvl_n = hit_hi ? L_HIGH : L_LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_q <= '0; mk_q <= '1; pr_q <= '0;
      rise_q <= '0; fall_q <= '0; pin_q <= '0;
      route_nmi_q <= 1'b0; ie_q <= 1'b0; nmi_q <= 1'b0; brk_q <= 1'b0;
      lvl_q <= L_NONE;
      for (int s = 0; s < STK; s++) stk_q[s] <= L_NONE;
    end else begin
      logic [NSRC-1:0] rf_n;
      rf_n = rf_q;
      if (reg_we && reg_sel == 3'd0) rf_n = reg_wdata;
      if (acc && take_msk) rf_n[win_idx] = 1'b0;
      rf_q <= rf_n | hw_set;
      if (reg_we && reg_sel == 3'd1) mk_q <= reg_wdata;
      if (reg_we && reg_sel == 3'd2) pr_q <= reg_wdata;
      if (reg_we && reg_sel == 3'd3) begin
        rise_q <= reg_wdata[EXT-1:0];
        fall_q <= reg_wdata[2*EXT-1:EXT];
        route_nmi_q <= reg_wdata[2*EXT];
      end
      if (acc) ie_q <= 1'b0;
      else if (reg_we && reg_sel == 3'd4) ie_q <= reg_wdata[0];
      nmi_q <= (wdt_ovf & route_nmi_q) | (nmi_q & ~(acc & take_nmi));
      brk_q <= brk_exec | (brk_q & ~(acc & take_brk));
      pin_q <= ext_pin;
      lvl_q <= lvl_n;
      for (int s = 0; s < STK; s++) stk_q[s] <= stk_n[s];
    end
  end

  always_comb begin
    case (reg_sel)
      3'd0: reg_rdata = rf_q;
      3'd1: reg_rdata = mk_q;
      3'd2: reg_rdata = pr_q;
      3'd3: reg_rdata = NSRC'({route_nmi_q, fall_q, rise_q});
      3'd4: reg_rdata = NSRC'({lvl_q, ie_q});
      default: reg_rdata = '0;
    endcase
  end

  AST_ACK_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n) (int_ack && int_req) |=> !ie_q); // R6
  AST_IE_GATE: assert property (@(posedge clk) disable iff (!rst_n) (int_req && !ie_q) |-> (nmi_q || brk_q)); // R5
  AST_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (int_req && lvl_q[1]) |-> (nmi_q || brk_q)); // R7
  AST_REQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) (int_req && !nmi_q && !brk_q) |-> ((rf_q & ~mk_q) != '0)); // R4
  AST_RETI_POP: assert property (@(posedge clk) disable iff (!rst_n) (reti && !int_ack) |=> (lvl_q == $past(stk_q[0]))); // R6
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) int_req |-> (!int_vec[0] && int_vec <= VW'(VBRK))); // R2
  AST_NMI_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (wdt_ovf && route_nmi_q) |=> wake); // R11
endmodule

// File: tb/vpic_ctrl_test.sv
module vpic_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:5] src_pulse = '0;
  logic [3:0] ext_pin = '0;
  logic wdt_ovf = 1'b0, brk_exec = 1'b0, reg_we = 1'b0, int_ack = 1'b0, reti = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [15:0] reg_wdata = '0, reg_rdata, int_vec;
  logic int_req, wake;
  int checks = 0, fails = 0;

  vpic_ctrl uut (.clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ext_pin(ext_pin), .wdt_ovf(wdt_ovf),
    .brk_exec(brk_exec), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_req(int_req), .int_vec(int_vec), .int_ack(int_ack), .reti(reti), .wake(wake));

  always #4 clk = ~clk;

  // {pending, mask, priority, expected vector (0 = no request)}
  localparam logic [63:0] TBL [7] = '{
    {16'h8000, 16'h0000, 16'h0000, 16'h0022},
    {16'h0A50, 16'h0000, 16'h0000, 16'h000C},
    {16'h0A50, 16'h0050, 16'h0000, 16'h0016},
    {16'h0A50, 16'h0000, 16'h0800, 16'h001A},
    {16'h0A50, 16'h0800, 16'h0A00, 16'h0016},
    {16'h0003, 16'h0000, 16'h0002, 16'h0006},
    {16'h0010, 16'h0010, 16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti = 1'b1; @(negedge clk); reti = 1'b0;
  endtask

  task automatic pulse_wdt();
    @(negedge clk); wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    do_reset();
    // R1 reset state
    rd(0, v); chk("R1 flags", v, 16'h0000);
    rd(1, v); chk("R1 masks", v, 16'hFFFF);
    rd(2, v); chk("R1 prio", v, 16'h0000);
    rd(3, v); chk("R1 cfg", v, 16'h0000);
    rd(4, v); chk("R1 ctrl", v, 16'h0000);
    chk("R1 int_req", {15'd0, int_req}, 16'h0000);

    // R2 R3 R4 table of selection cases
    wr(4, 16'h0001);
    for (int n = 0; n < 7; n++) begin
      wr(1, TBL[n][47:32]);
      wr(2, TBL[n][31:16]);
      wr(0, TBL[n][63:48]);
      chk($sformatf("R2/R3/R4 entry %0d req", n), {15'd0, int_req}, {15'd0, TBL[n][15:0] != 16'h0});
      if (TBL[n][15:0] != 16'h0) chk($sformatf("R2/R3 entry %0d vec", n), int_vec, TBL[n][15:0]);
      rd(0, v); chk($sformatf("R4 entry %0d flags kept", n), v, TBL[n][63:48]);
      wr(0, 16'h0000);
    end

    // R11 wake and R5 enable gating
    do_reset();
    wr(0, 16'h0008);
    chk("R11 masked no wake", {15'd0, wake}, 16'h0000);
    chk("R4 masked no req", {15'd0, int_req}, 16'h0000);
    wr(1, 16'hFFF7);
    chk("R11 wake unmasked", {15'd0, wake}, 16'h0001);
    chk("R5 ie off no req", {15'd0, int_req}, 16'h0000);

    // R6 R7 nesting
    do_reset();
    wr(1, 16'h0000); wr(2, 16'h0080); wr(4, 16'h0001);
    wr(0, 16'h0200);
    chk("R6 vec src9", int_vec, 16'h0016);
    pulse_ack();
    rd(4, v); chk("R6 ack level1 ie0", v, 16'h0002);
    rd(0, v); chk("R6 flag cleared", v, 16'h0000);
    wr(4, 16'h0001);
    wr(0, 16'h1000);
    chk("R7 low blocked at level1", {15'd0, int_req}, 16'h0000);
    wr(0, 16'h1080);
    chk("R7 high preempts vec", int_vec, 16'h0012);
    pulse_ack();
    rd(4, v); chk("R7 level2", v, 16'h0004);
    wr(4, 16'h0001);
    chk("R7 level2 blocks", {15'd0, int_req}, 16'h0000);
    pulse_reti();
    rd(4, v); chk("R6 reti to level1", v, 16'h0003);
    chk("R7 still blocked", {15'd0, int_req}, 16'h0000);
    pulse_reti();
    rd(4, v); chk("R6 reti to level0", v, 16'h0001);
    chk("R6 pending src12 vec", int_vec, 16'h001C);

    // R12 same-cycle set vs clear
    do_reset();
    wr(1, 16'h0000); wr(4, 16'h0001); wr(0, 16'h0020);
    chk("R12 presented src5", int_vec, 16'h000E);
    @(negedge clk); int_ack = 1'b1; src_pulse[5] = 1'b1;
    @(negedge clk); int_ack = 1'b0; src_pulse[5] = 1'b0;
    rd(0, v); chk("R12 ack vs set keeps flag", v, 16'h0020);
    rd(4, v); chk("R12 level1 ie0", v, 16'h0002);
    @(negedge clk); reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 16'h0000; src_pulse[6] = 1'b1;
    @(negedge clk); reg_we = 1'b0; src_pulse[6] = 1'b0;
    rd(0, v); chk("R12 write vs set", v, 16'h0040);

    // R8 watchdog routing
    do_reset();
    pulse_wdt();
    rd(0, v); chk("R8 wdt maskable flag0", v, 16'h0001);
    wr(0, 16'h0000);
    wr(3, 16'h0100);
    pulse_wdt();
    chk("R8 nmi req ie0", {15'd0, int_req}, 16'h0001);
    chk("R8 nmi vec", int_vec, 16'h0004);
    chk("R11 wake on nmi", {15'd0, wake}, 16'h0001);
    pulse_ack();
    rd(4, v); chk("R8 level3", v, 16'h0006);
    pulse_wdt();
    chk("R8 nmi held in nmi", {15'd0, int_req}, 16'h0000);
    pulse_reti();
    chk("R8 nmi after reti", {15'd0, int_req}, 16'h0001);
    pulse_ack(); pulse_reti();

    // R9 break
    do_reset();
    @(negedge clk); brk_exec = 1'b1; @(negedge clk); brk_exec = 1'b0;
    chk("R9 brk ie0 vec", int_vec, 16'h003E);
    pulse_ack();
    chk("R9 brk served", {15'd0, int_req}, 16'h0000);
    pulse_reti();
    wr(1, 16'h0000); wr(4, 16'h0001); wr(0, 16'h0001);
    @(negedge clk); brk_exec = 1'b1; @(negedge clk); brk_exec = 1'b0;
    chk("R9 brk over maskable", int_vec, 16'h003E);
    pulse_ack();
    rd(4, v); chk("R9 level kept ie0", v, 16'h0000);
    pulse_reti();

    // R10 edge selection
    do_reset();
    wr(3, 16'h0065);
    @(negedge clk); ext_pin = 4'b1111; @(negedge clk);
    rd(0, v); chk("R10 rising edges", v, 16'h000A);
    wr(0, 16'h0000);
    @(negedge clk); ext_pin = 4'b0000; @(negedge clk);
    rd(0, v); chk("R10 falling edges", v, 16'h000C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule